// File: doc/BRIEF.md
# Clock Buffer Power-Mode Controller

This block chooses the operating mode of a zero-delay differential clock fan-out buffer. It combines three conditions into one decision: an active-low power-down pin, a digital flag that reports whether the analog supply is present, and an automatic shut-down when the reference clock runs too slowly. From that decision it drives the PLL enable, the PLL-bypass select, the input-receiver enable and a single tri-state control that covers every differential output pair, the feedback pair included.

A free-running local clock samples the reference clock through a synchronizer. It counts the reference's rising edges over a fixed window of local cycles. A window below a low limit counts toward declaring the reference slow. A window at or above a higher limit counts toward declaring it fast again. Either change needs two consecutive qualifying windows. The detector does not use the input receivers, so it keeps running while they are disabled. The reference given to this block must toggle slower than half the local clock rate, so it is normally a pre-divided copy. After the block leaves a shut-down or changes mode, a stable flag stays low until a programmable settle time has passed.

Top module: `clkbuf_pwr_ctl`

## Requirements
- R1: While `pd_n` is 0, the outputs are `pll_en`=0, `pll_bypass`=0, `rx_en`=0 and `out_hiz`=1, for either level of `avdd_ok`.
- R2: With `pd_n`=1, `avdd_ok`=0 and the reference not slow, the outputs are `pll_bypass`=1, `pll_en`=0, `rx_en`=1 and `out_hiz`=0, so the reference passes straight through.
- R3: With `pd_n`=1, `avdd_ok`=1 and the reference not slow, the outputs are `pll_en`=1, `pll_bypass`=0, `rx_en`=1 and `out_hiz`=0.
- R4: While the reference is judged slow, the outputs are those of R1 whatever `pd_n` and `avdd_ok` are. Edge counting continues while `rx_en`=0, so a reference that speeds up during a pin power-down is already judged fast when `pd_n` returns to 1.
- R5: Each window lasts WIN_CYCLES local cycles and counts synchronized rising edges of `ref_clk`. A window with fewer than SLOW_LIM edges is a low window. The slow state is entered only after two consecutive low windows. A steady count of SLOW_LIM or more never enters it.
- R6: The slow state is left only after two consecutive windows with at least FAST_LIM edges. Counts from SLOW_LIM to FAST_LIM-1 keep the current state.
- R7: `clk_stable` is 0 in the R1 state and in the first cycle of every mode change. After a change into the R2 or R3 state, it rises exactly STAB_CYCLES cycles after the cycle in which the new mode first shows at the outputs.
- R8: During reset the outputs hold the R1 values with `clk_stable`=0, and the slow state is clear. After reset, with `pd_n`=1 and `avdd_ok`=1, the R3 state is reached without waiting for any window.
- R9: A change on `pd_n` or `avdd_ok` reaches the outputs on the third rising clock edge after it: two synchronizer stages and then the mode register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running local sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_n | input | 1 | Asynchronous power-down pin, low = shut down |
| avdd_ok | input | 1 | Asynchronous flag, 1 = analog supply present |
| ref_clk | input | 1 | Reference clock (pre-divided), sampled by `clk` |
| pll_en | output | 1 | 1 = PLL running |
| pll_bypass | output | 1 | 1 = outputs follow the reference, PLL bypassed |
| rx_en | output | 1 | 1 = differential input receivers enabled |
| out_hiz | output | 1 | 1 = all output pairs, feedback included, high impedance |
| clk_stable | output | 1 | 1 = current mode has settled |

## Verification
The bench sweeps every combination of the two pins and drives reference periods that fall clearly below, inside and above the hysteresis band. A detector built without hysteresis would drop out, or fail to recover, under the in-band period. A detector that acted on a single window would change state too early, and the bench checks the mode before two full windows can have passed. The bench also lets the reference recover or fail while the pin holds the block in power-down. A detector gated by the receivers would then leave the block in the wrong state when the pin is released. The settle count is measured to the exact cycle after each exit, and a pin change is checked on the cycle before and the cycle of its expected arrival, so an off-by-one load or an extra register stage shows up.

// File: rtl/clkbuf_pwr_pkg.sv
// Shared types for the clock-buffer power-mode controller.
package clkbuf_pwr_pkg;
    // Operating modes; encoding is internal to the block.
    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_BYPASS = 2'd1,
        MODE_RUN    = 2'd2
    } mode_e;
endpackage

// File: rtl/clkbuf_pwr_sync.sv
// Multi-stage synchronizer for a vector of independent asynchronous bits.
// Assumes each bit may be sampled on its own; no bus coherence is given.
// Every stage resets to zero.
module clkbuf_pwr_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift the asynchronous inputs through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/clkbuf_pwr_freqdet.sv
// Reference-frequency detector. Counts rising edges of an already
// synchronized reference over fixed windows of local cycles. The slow flag
// is set after two consecutive windows below SLOW_LIM and cleared after two
// consecutive windows at or above FAST_LIM. Assumes the reference toggles
// slower than half the local clock rate.
module clkbuf_pwr_freqdet #(
    parameter int WIN_CYCLES = 64,
    parameter int SLOW_LIM   = 6,
    parameter int FAST_LIM   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_s,
    output logic slow_o
);
    localparam int WW = $clog2(WIN_CYCLES);
    localparam int CW = $clog2(WIN_CYCLES + 1);

    logic          ref_d_q;
    logic          rise;
    logic [WW-1:0] win_q;
    logic [CW-1:0] edges_q;
    logic [CW-1:0] total;
    logic          win_end;
    logic          low_win;
    logic          high_win;
    logic          qual;
    logic          prev_qual_q;
    logic          slow_q;

    assign rise     = ref_s & ~ref_d_q;
    assign total    = edges_q + CW'(rise);
    assign win_end  = (win_q == WW'(WIN_CYCLES - 1));
    assign low_win  = (total < CW'(SLOW_LIM));
    assign high_win = (total >= CW'(FAST_LIM));
    assign qual     = slow_q ? high_win : low_win;

    // Delay the synchronized reference for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_d_q <= 1'b0;
        else        ref_d_q <= ref_s;
    end

    // Advance the window position and accumulate edges inside it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q   <= '0;
            edges_q <= '0;
        end else if (win_end) begin
            win_q   <= '0;
            edges_q <= '0;
        end else begin
            win_q   <= win_q + 1'b1;
            edges_q <= total;
        end
    end

    // Flip the slow flag after two consecutive qualifying windows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slow_q      <= 1'b0;
            prev_qual_q <= 1'b0;
        end else if (win_end) begin
            if (qual && prev_qual_q) begin
                slow_q      <= ~slow_q;
                prev_qual_q <= 1'b0;
            end else begin
                prev_qual_q <= qual;
            end
        end
    end

    assign slow_o = slow_q;

    // R5: the slow flag changes only at a window boundary.
    p_flip_on_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_q != $past(slow_q)) |-> $past(win_end));
    // R5: entering slow follows a low window.
    p_enter_needs_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slow_q) |-> $past(low_win));
    // R6: leaving slow follows a high window.
    p_leave_needs_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slow_q) |-> $past(high_win));
endmodule

// File: rtl/clkbuf_pwr_mode.sv
// Mode decision and settle timer. Pin power-down or a slow reference gives
// the off state; a missing analog supply gives bypass; otherwise the PLL
// runs. Inputs must already be synchronized to clk. STAB_CYCLES >= 1.
module clkbuf_pwr_mode
    import clkbuf_pwr_pkg::*;
#(
    parameter int STAB_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_n_s,
    input  logic avdd_s,
    input  logic slow_i,
    output logic pll_en,
    output logic pll_bypass,
    output logic rx_en,
    output logic out_hiz,
    output logic clk_stable
);
    localparam int SW = $clog2(STAB_CYCLES + 1);

    mode_e         mode_d;
    mode_e         mode_q;
    logic [SW-1:0] stab_q;

    // Pick the next mode by priority: off, then bypass, then run.
    always_comb begin
        if (!pd_n_s || slow_i) mode_d = MODE_OFF;
        else if (!avdd_s)      mode_d = MODE_BYPASS;
        else                   mode_d = MODE_RUN;
    end

    // Register the mode.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_OFF;
        else        mode_q <= mode_d;
    end

    // Restart the settle timer on every mode change and count it down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stab_q <= '0;
        end else if (mode_d != mode_q) begin
            stab_q <= (mode_d == MODE_OFF) ? '0 : SW'(STAB_CYCLES);
        end else if (stab_q != '0) begin
            stab_q <= stab_q - 1'b1;
        end
    end

    // Decode the registered mode into control outputs.
    always_comb begin
        pll_en     = (mode_q == MODE_RUN);
        pll_bypass = (mode_q == MODE_BYPASS);
        rx_en      = (mode_q != MODE_OFF);
        out_hiz    = (mode_q == MODE_OFF);
        clk_stable = (mode_q != MODE_OFF) && (stab_q == '0);
    end

    // R1: a low pin forces the off state one cycle later.
    p_pin_forces_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pd_n_s) |-> (out_hiz && !rx_en && !pll_en && !pll_bypass));
    // R4: a slow reference forces the off state one cycle later.
    p_slow_forces_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(slow_i) |-> (out_hiz && !rx_en && !pll_en));
    // R2: pin high, supply missing and reference fast give bypass.
    p_bypass_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pd_n_s) && !$past(avdd_s) && !$past(slow_i))
            |-> (pll_bypass && !pll_en && rx_en && !out_hiz));
    // R3: pin high, supply present and reference fast give PLL run.
    p_run_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pd_n_s) && $past(avdd_s) && !$past(slow_i))
            |-> (pll_en && !pll_bypass && rx_en && !out_hiz));
    // R7: the stable flag is low in the first cycle of any new mode.
    p_change_clears_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != $past(mode_q)) |-> !clk_stable);
    // R7: stable never shows while outputs are tri-stated.
    p_stable_needs_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stable |-> !out_hiz);
endmodule

// File: rtl/clkbuf_pwr_ctl.sv
// Top of the clock-buffer power-mode controller. Synchronizes the pins and
// the reference into the local clock domain, judges the reference rate and
// derives the mode controls. Assumes ref_clk toggles slower than clk/2.
module clkbuf_pwr_ctl #(
    parameter int WIN_CYCLES  = 64,
    parameter int SLOW_LIM    = 6,
    parameter int FAST_LIM    = 8,
    parameter int STAB_CYCLES = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_n,
    input  logic avdd_ok,
    input  logic ref_clk,
    output logic pll_en,
    output logic pll_bypass,
    output logic rx_en,
    output logic out_hiz,
    output logic clk_stable
);
    logic [2:0] sync_v;
    logic       slow;

    clkbuf_pwr_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ref_clk, avdd_ok, pd_n}),
        .sync_o  (sync_v)
    );

    clkbuf_pwr_freqdet #(
        .WIN_CYCLES (WIN_CYCLES),
        .SLOW_LIM   (SLOW_LIM),
        .FAST_LIM   (FAST_LIM)
    ) freqdet_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_s  (sync_v[2]),
        .slow_o (slow)
    );

    clkbuf_pwr_mode #(
        .STAB_CYCLES (STAB_CYCLES)
    ) mode_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pd_n_s     (sync_v[0]),
        .avdd_s     (sync_v[1]),
        .slow_i     (slow),
        .pll_en     (pll_en),
        .pll_bypass (pll_bypass),
        .rx_en      (rx_en),
        .out_hiz    (out_hiz),
        .clk_stable (clk_stable)
    );
endmodule

// File: tb/clkbuf_pwr_ctl_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: small window, narrow band and short settle time.
module clkbuf_pwr_ctl_tb_top;
    localparam int WIN  = 32;
    localparam int SLOW = 4;
    localparam int FAST = 6;
    localparam int STAB = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_n = 1'b1;
    logic avdd_ok = 1'b1;
    logic ref_clk = 1'b0;
    logic pll_en, pll_bypass, rx_en, out_hiz, clk_stable;

    int half = 2;      // reference half period in local cycles, 0 = stopped
    int rcnt = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    clkbuf_pwr_ctl #(
        .WIN_CYCLES  (WIN),
        .SLOW_LIM    (SLOW),
        .FAST_LIM    (FAST),
        .STAB_CYCLES (STAB),
        .SYNC_STAGES (2)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pd_n       (pd_n),
        .avdd_ok    (avdd_ok),
        .ref_clk    (ref_clk),
        .pll_en     (pll_en),
        .pll_bypass (pll_bypass),
        .rx_en      (rx_en),
        .out_hiz    (out_hiz),
        .clk_stable (clk_stable)
    );

    always #2.5 clk = ~clk;

    // Reference generator: toggles on falling local edges.
    always @(negedge clk) begin
        if (half != 0) begin
            rcnt = rcnt + 1;
            if (rcnt >= half) begin
                ref_clk = ~ref_clk;
                rcnt = 0;
            end
        end
    end

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic chk_mode(input string req, input logic e_pll, input logic e_byp,
                            input logic e_rx, input logic e_hiz);
        chk(req, "pll_en", pll_en, e_pll);
        chk(req, "pll_bypass", pll_bypass, e_byp);
        chk(req, "rx_en", rx_en, e_rx);
        chk(req, "out_hiz", out_hiz, e_hiz);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_mode(input logic e_pll, input logic e_byp, input logic e_hiz);
        int n = 0;
        while (!(pll_en === e_pll && pll_bypass === e_byp && out_hiz === e_hiz) && n < 400) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Called at the first sample that shows the new mode.
    task automatic chk_stab(input string req);
        int k = 0;
        while (clk_stable !== 1'b1 && k < STAB + 40) begin
            @(negedge clk);
            k++;
        end
        checks++;
        if (k != STAB) begin
            errors++;
            $display("FAIL %s settle cycles: actual %0d expected %0d", req, k, STAB);
        end
    endtask

    initial begin
        // R8: reset state.
        cyc(3);
        chk_mode("R8", 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R8", "clk_stable", clk_stable, 1'b0);
        rst_n = 1'b1;
        wait_mode(1'b1, 1'b0, 1'b0);
        chk_mode("R3", 1'b1, 1'b0, 1'b1, 1'b0);
        chk("R7", "stable low at mode entry", clk_stable, 1'b0);
        chk_stab("R7");

        // R9: exact pin latency, R1: off state.
        pd_n = 1'b0;
        cyc(2);
        chk("R9", "out_hiz before third edge", out_hiz, 1'b0);
        cyc(1);
        chk("R9", "out_hiz at third edge", out_hiz, 1'b1);
        chk_mode("R1", 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R7", "stable low when off", clk_stable, 1'b0);
        avdd_ok = 1'b0;
        cyc(6);
        chk_mode("R1", 1'b0, 1'b0, 1'b0, 1'b1);

        // R2: bypass, then R3 from bypass with restarted settle.
        pd_n = 1'b1;
        wait_mode(1'b0, 1'b1, 1'b0);
        chk_mode("R2", 1'b0, 1'b1, 1'b1, 1'b0);
        chk_stab("R7");
        avdd_ok = 1'b1;
        wait_mode(1'b1, 1'b0, 1'b0);
        chk("R7", "stable cleared on bypass to run", clk_stable, 1'b0);
        chk_stab("R7");

        // R1 R2 R3: sweep of both pins with a fast reference.
        for (int p = 0; p < 2; p++) begin
            for (int a = 0; a < 2; a++) begin
                pd_n = p[0];
                avdd_ok = a[0];
                cyc(8);
                if (p == 0)      chk_mode("R1", 1'b0, 1'b0, 1'b0, 1'b1);
                else if (a == 0) chk_mode("R2", 1'b0, 1'b1, 1'b1, 1'b0);
                else             chk_mode("R3", 1'b1, 1'b0, 1'b1, 1'b0);
            end
        end
        cyc(STAB + 5);

        // R5: slow reference needs two windows; R4: then off with pin high.
        half = 8;
        cyc(40);
        chk_mode("R5", 1'b1, 1'b0, 1'b1, 1'b0);
        cyc(110);
        chk_mode("R4", 1'b0, 1'b0, 1'b0, 1'b1);

        // R6: in-band rate keeps slow; fast needs two windows to leave.
        half = 4;
        cyc(300);
        chk_mode("R6", 1'b0, 1'b0, 1'b0, 1'b1);
        half = 2;
        cyc(40);
        chk_mode("R6", 1'b0, 1'b0, 1'b0, 1'b1);
        wait_mode(1'b1, 1'b0, 1'b0);
        chk_mode("R6", 1'b1, 1'b0, 1'b1, 1'b0);
        chk_stab("R7");

        // R5: in-band rate from fast never enters slow.
        half = 4;
        cyc(300);
        chk_mode("R5", 1'b1, 1'b0, 1'b1, 1'b0);

        // R4: stopped reference shuts down.
        half = 0;
        cyc(150);
        chk_mode("R4", 1'b0, 1'b0, 1'b0, 1'b1);

        // R4: detector recovers while the pin holds receivers off.
        pd_n = 1'b0;
        half = 2;
        cyc(150);
        pd_n = 1'b1;
        cyc(6);
        chk_mode("R4", 1'b1, 1'b0, 1'b1, 1'b0);

        // R4: detector goes slow while the pin holds receivers off.
        pd_n = 1'b0;
        half = 8;
        cyc(150);
        pd_n = 1'b1;
        cyc(6);
        chk_mode("R4", 1'b0, 1'b0, 1'b0, 1'b1);
        half = 2;
        avdd_ok = 1'b0;
        wait_mode(1'b0, 1'b1, 1'b0);
        chk_mode("R2", 1'b0, 1'b1, 1'b1, 1'b0);
        chk_stab("R7");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule